// File: doc/BRIEF.md
# Up-Counting Compare Timer

A 16-bit timer that counts upward from zero and restarts once it reaches the value held in compare register A, so compare A sets the period. Three single-cycle event outputs mark the period rollover, a match on compare A and a match on compare B. While counting is off, or while compare A is zero, the counter stays at zero and no event fires.

Software reaches the timer through a small byte-addressed register port. Each access lasts one cycle and may be a byte or a halfword. It gets a response one cycle later that carries the read data and an error flag. Illegal accesses are refused without side effects:
- wrong size for the register,
- unmapped address,
- write to the counter,
- nonzero reserved mode bits,
- enable and load set together.

A two-byte mode register holds the run controls. Two 8-bit compare-mode registers are plain storage for downstream logic.

Top module: `cmp_tmr`

## Requirements
- R1: After reset every register reads zero, the counter is zero, and all three event outputs and `rvalid_o` are low.
- R2: The counter reads zero while stopped. An accepted write to mode byte 1 with bit 7 (enable) set clears it to zero. It then rises by one each cycle.
- R3: With compare A = C > 0, `match_a_o` is high for one cycle while the count equals C. In the next cycle the count is zero and `evt_period_o` is high for one cycle, so the period is C+1 cycles.
- R4: While compare A is zero the timer is idle: the counter reads zero and no event fires, even with enable set.
- R5: `match_b_o` is high for exactly the cycles in which the timer runs and the count equals compare B.
- R6: Clearing enable stops and zeroes the counter at the next edge. Any accepted write to mode byte 1 that keeps enable set restarts the count from zero.
- R7: Reserved mode bits are bits 0-2 of byte 1 (mask 0x07) and bits 2, 3 and 5 of byte 0 (mask 0x2C). A write that puts a one in any of them returns error, and the whole write is discarded.
- R8: A write that sets enable (byte 1 bit 7) and load (byte 1 bit 6) together returns error and is discarded.
- R9: The mode register is at addresses 0x0 (byte 0) and 0x1 (byte 1). Byte accesses work at either address. A halfword access works only at 0x0, with byte 0 in data bits 7:0. Any halfword access at an odd address returns error.
- R10: Compare A (0x4/0x5) and compare B (0x6/0x7) take byte and halfword accesses, with the low byte at the even address. The compare-mode A (0x8) and B (0x9) registers take byte accesses only, and a halfword access there returns error.
- R11: The counter at 0x2/0x3 is read-only, and a write to it returns error. Addresses 0xA-0xF return error, and the response data of an error is zero.
- R12: Every access gets `rvalid_o` one cycle later. A byte read returns its byte in data bits 7:0 with bits 15:8 zero. A write returns zero data.
- R13: If compare A is lowered below the current count while running, the counter wraps to zero at the next edge and `evt_period_o` fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Byte address |
| size_i | input | 1 | 0 = byte, 1 = halfword |
| wdata_i | input | 16 | Write data (a byte write uses bits 7:0) |
| rvalid_o | output | 1 | Response valid, one cycle after `req_i` |
| rdata_o | output | 16 | Read data |
| err_o | output | 1 | Access was refused |
| evt_period_o | output | 1 | Period rollover pulse |
| match_a_o | output | 1 | Count equals compare A |
| match_b_o | output | 1 | Count equals compare B |

## Verification
The bench counts edges from the one at which an access is sampled. A bus response is due one edge later, so a driver queues the expected response when it issues the access, and a monitor pops and compares it on the next falling edge. After an enabling write, the count is k after k further edges, `match_a_o` rises C edges later and `evt_period_o` one edge after that. The event checks wait exactly these numbers of falling edges before they sample. Counter reads issued back to back after that write must return 0, 1, 2.

// File: rtl/cmp_tmr_pkg.sv
package cmp_tmr_pkg;
  localparam int unsigned DW     = 16;
  localparam int unsigned AW     = 4;
  localparam int unsigned NCMP   = 2;
  localparam int unsigned EN_BIT = 7;
  localparam int unsigned LD_BIT = 6;

  // register index = addr[3:1]
  localparam logic [2:0] RI_MODE  = 3'd0;
  localparam logic [2:0] RI_CNT   = 3'd1;
  localparam logic [2:0] RI_CMP0  = 3'd2;
  localparam logic [2:0] RI_CMODE = 3'd4;

  localparam logic [7:0] MODE_LO_RSV = 8'h2C;
  localparam logic [7:0] MODE_HI_RSV = 8'h07;
endpackage

// File: rtl/cmp_tmr_regs.sv
module cmp_tmr_regs
  import cmp_tmr_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic                     we_i,
  input  logic [AW-1:0]            addr_i,
  input  logic                     size_i,
  input  logic [DW-1:0]            wdata_i,
  input  logic [DW-1:0]            cnt_i,
  output logic                     rvalid_o,
  output logic [DW-1:0]            rdata_o,
  output logic                     err_o,
  output logic                     en_o,
  output logic                     restart_o,
  output logic [NCMP-1:0][DW-1:0]  cmp_o
);
  logic [7:0]              mode_lo_q, mode_hi_q;
  logic [NCMP-1:0][DW-1:0] cmp_q;
  logic [NCMP-1:0][7:0]    cmode_q;

  logic            is_hw, is_odd, wr_lo, wr_hi, bad, acc;
  logic [2:0]      reg_idx;
  logic [7:0]      lo_d, hi_d;
  logic            sel_mode, sel_cnt, sel_cmode;
  logic [NCMP-1:0] sel_cmp;
  logic [DW-1:0]   rd_val;

  assign is_hw     = size_i;
  assign is_odd    = addr_i[0];
  assign reg_idx   = addr_i[3:1];
  assign lo_d      = wdata_i[7:0];
  assign hi_d      = is_hw ? wdata_i[15:8] : wdata_i[7:0];
  assign wr_lo     = is_hw || !is_odd;
  assign wr_hi     = is_hw || is_odd;
  assign sel_mode  = (reg_idx == RI_MODE);
  assign sel_cnt   = (reg_idx == RI_CNT);
  assign sel_cmode = (reg_idx == RI_CMODE);

  for (genvar k = 0; k < NCMP; k++) begin : g_sel
    assign sel_cmp[k] = (reg_idx == RI_CMP0 + 3'(k));
  end

  always_comb begin
    bad    = is_hw && is_odd;
    rd_val = '0;
    if (sel_mode) begin
      rd_val = {mode_hi_q, mode_lo_q};
      if (we_i) begin
        if (wr_lo && |(lo_d & MODE_LO_RSV)) bad = 1'b1;
        if (wr_hi && (|(hi_d & MODE_HI_RSV) || (hi_d[EN_BIT] && hi_d[LD_BIT]))) bad = 1'b1;
      end
    end else if (sel_cnt) begin
      rd_val = cnt_i;
      if (we_i) bad = 1'b1;
    end else if (sel_cmode) begin
      rd_val = {cmode_q[1], cmode_q[0]};
      if (is_hw) bad = 1'b1;
    end else if (|sel_cmp) begin
      for (int k = 0; k < NCMP; k++)
        if (sel_cmp[k]) rd_val = cmp_q[k];
    end else begin
      bad = 1'b1;
    end
  end

  assign acc = req_i && we_i && !bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_lo_q <= '0;
      mode_hi_q <= '0;
      cmp_q     <= '0;
      cmode_q   <= '0;
    end else if (acc) begin
      if (sel_mode) begin
        if (wr_lo) mode_lo_q <= lo_d;
        if (wr_hi) mode_hi_q <= hi_d;
      end
      for (int k = 0; k < NCMP; k++) begin
        if (sel_cmp[k]) begin
          if (wr_lo) cmp_q[k][7:0]  <= lo_d;
          if (wr_hi) cmp_q[k][15:8] <= hi_d;
        end
      end
      if (sel_cmode) cmode_q[is_odd] <= lo_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      err_o    <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= req_i;
      err_o    <= req_i && bad;
      if (req_i && !we_i && !bad)
        rdata_o <= is_hw ? rd_val : {8'h00, (is_odd ? rd_val[15:8] : rd_val[7:0])};
      else
        rdata_o <= '0;
    end
  end

  assign en_o      = mode_hi_q[EN_BIT];
  assign restart_o = acc && sel_mode && wr_hi;
  assign cmp_o     = cmp_q;

  a_r12_rsp_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rvalid_o);
  a_r11_cnt_write_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i[3:1] == RI_CNT) |=> err_o);
  a_r9_odd_half_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && size_i && addr_i[0]) |=> err_o);
  a_r7_rsv_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_lo_q & MODE_LO_RSV) == 8'h00) && ((mode_hi_q & MODE_HI_RSV) == 8'h00));
  a_r8_no_en_ld: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mode_hi_q[EN_BIT] && mode_hi_q[LD_BIT]));
endmodule

// File: rtl/cmp_tmr_count.sv
module cmp_tmr_count #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             run_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             period_o
);
  logic             run;
  logic [CNT_W-1:0] cnt_q;
  logic             per_q;

  assign run = en_i && (limit_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      per_q <= 1'b0;
    end else if (!run || restart_i) begin
      cnt_q <= '0;
      per_q <= 1'b0;
    end else if (cnt_q >= limit_i) begin
      cnt_q <= '0;
      per_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
      per_q <= 1'b0;
    end
  end

  assign run_o    = run;
  assign cnt_o    = run ? cnt_q : '0;
  assign period_o = per_q;

  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !restart_i && cnt_q < limit_i) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
  a_r3_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !restart_i && cnt_q >= limit_i) |=> (cnt_q == '0 && period_o));
  a_r6_stop_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run || restart_i) |=> (cnt_q == '0));
  a_r4_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (limit_i == '0) |=> (cnt_q == '0 && !period_o));
endmodule

// File: rtl/cmp_tmr_match.sv
module cmp_tmr_match #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             run_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] ref_i,
  output logic             hit_o
);
  assign hit_o = run_i && (cnt_i == ref_i);
endmodule

// File: rtl/cmp_tmr.sv
module cmp_tmr
  import cmp_tmr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [3:0]    addr_i,
  input  logic          size_i,
  input  logic [15:0]   wdata_i,
  output logic          rvalid_o,
  output logic [15:0]   rdata_o,
  output logic          err_o,
  output logic          evt_period_o,
  output logic          match_a_o,
  output logic          match_b_o
);
  logic                    en, restart, run;
  logic [DW-1:0]           cnt;
  logic [NCMP-1:0][DW-1:0] cmp;
  logic [NCMP-1:0]         hit;

  cmp_tmr_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .size_i    (size_i),
    .wdata_i   (wdata_i),
    .cnt_i     (cnt),
    .rvalid_o  (rvalid_o),
    .rdata_o   (rdata_o),
    .err_o     (err_o),
    .en_o      (en),
    .restart_o (restart),
    .cmp_o     (cmp)
  );

  cmp_tmr_count #(.CNT_W(DW)) u_count (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en),
    .restart_i (restart),
    .limit_i   (cmp[0]),
    .run_o     (run),
    .cnt_o     (cnt),
    .period_o  (evt_period_o)
  );

  for (genvar k = 0; k < NCMP; k++) begin : g_match
    cmp_tmr_match #(.CNT_W(DW)) u_match (
      .run_i (run),
      .cnt_i (cnt),
      .ref_i (cmp[k]),
      .hit_o (hit[k])
    );
  end

  assign match_a_o = hit[0];
  assign match_b_o = hit[1];

  // R3: A match is followed by rollover unless the count is restarted or stopped
  a_r3_period_after_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_a_o && !restart && run) |=> evt_period_o);
endmodule

// File: tb/cmp_tmr_bench.sv
`timescale 1ns/1ps
module cmp_tmr_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, size = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        rvalid, err, evt_per, m_a, m_b;
  logic [15:0] rdata;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [16:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  cmp_tmr u_cmp_tmr (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .rvalid_o(rvalid), .rdata_o(rdata),
    .err_o(err), .evt_period_o(evt_per), .match_a_o(m_a), .match_b_o(m_b)
  );

  task automatic chk(input string r, input logic [16:0] act, input logic [16:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic evts(input string r, input logic p, input logic a, input logic b);
    chk(r, {14'd0, evt_per, m_a, m_b}, {14'd0, p, a, b});
  endtask

  // driver: issue one access, queue its expected response
  task automatic bus(input string r, input logic w, input logic [3:0] a, input logic hw,
                     input logic [15:0] wd, input logic e, input logic [15:0] ed);
    exp_q.push_back({e, ed});
    tag_q.push_back(r);
    req = 1'b1; we = w; addr = a; size = hw; wdata = wd;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare each response with the queued expectation
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R12 unexpected response actual=%h expected=none", {err, rdata});
      end else begin
        logic [16:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {err, rdata}, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    waitn(3);
    rst_n = 1'b1;
    waitn(1);
    // R1 reset state
    chk("R1 rvalid", {16'd0, rvalid}, 17'd0);
    evts("R1 events", 0, 0, 0);
    bus("R1 mode", 0, 4'h0, 1, 0, 0, 16'h0000);
    bus("R1 cmpA", 0, 4'h4, 1, 0, 0, 16'h0000);
    bus("R1 cnt", 0, 4'h2, 1, 0, 0, 16'h0000);
    // R10 compare and compare-mode access sizes
    bus("R10 wr cmpA hw", 1, 4'h4, 1, 16'h1234, 0, 16'h0000);
    bus("R10 rd cmpA lo", 0, 4'h4, 0, 0, 0, 16'h0034);
    bus("R12 rd cmpA hi byte", 0, 4'h5, 0, 0, 0, 16'h0012);
    bus("R10 wr cmpA byte hi", 1, 4'h5, 0, 16'h00AB, 0, 16'h0000);
    bus("R10 rd cmpA hw", 0, 4'h4, 1, 0, 0, 16'hAB34);
    bus("R10 wr cmodeA", 1, 4'h8, 0, 16'h005A, 0, 16'h0000);
    bus("R10 rd cmodeA", 0, 4'h8, 0, 0, 0, 16'h005A);
    bus("R10 hw cmode err", 1, 4'h8, 1, 16'hFFFF, 1, 16'h0000);
    bus("R10 cmodeB kept", 0, 4'h9, 0, 0, 0, 16'h0000);
    bus("R10 cmodeA kept", 0, 4'h8, 0, 0, 0, 16'h005A);
    // R11 read-only counter and unmapped space
    bus("R11 cnt write", 1, 4'h2, 1, 16'h0005, 1, 16'h0000);
    bus("R11 unmapped", 0, 4'hA, 0, 0, 1, 16'h0000);
    bus("R11 unmapped hi", 0, 4'hE, 1, 0, 1, 16'h0000);
    bus("R9 odd hw read", 0, 4'h5, 1, 0, 1, 16'h0000);
    // R7 reserved bits
    bus("R7 hi rsv", 1, 4'h1, 0, 16'h0081, 1, 16'h0000);
    bus("R7 hi kept", 0, 4'h1, 0, 0, 0, 16'h0000);
    bus("R7 lo rsv", 1, 4'h0, 0, 16'h0004, 1, 16'h0000);
    bus("R7 lo kept", 0, 4'h0, 0, 0, 0, 16'h0000);
    bus("R7 lo legal", 1, 4'h0, 0, 16'h0053, 0, 16'h0000);
    bus("R7 lo rd", 0, 4'h0, 0, 0, 0, 16'h0053);
    // R8 enable with load
    bus("R8 en+ld", 1, 4'h1, 0, 16'h00C0, 1, 16'h0000);
    bus("R8 kept", 0, 4'h1, 0, 0, 0, 16'h0000);
    evts("R8 no start", 0, 0, 0);
    // R9 halfword mode access
    bus("R9 hw at odd", 1, 4'h1, 1, 16'h0080, 1, 16'h0000);
    bus("R9 hw at even", 1, 4'h0, 1, 16'h4053, 0, 16'h0000);
    bus("R9 rd hw", 0, 4'h0, 1, 0, 0, 16'h4053);
    bus("R9 rd byte1", 0, 4'h1, 0, 0, 0, 16'h0040);
    // R4 idle with compare A zero
    bus("R4 cmpA=0", 1, 4'h4, 1, 16'h0000, 0, 16'h0000);
    bus("R4 enable", 1, 4'h1, 0, 16'h0080, 0, 16'h0000);
    waitn(4);
    evts("R4 idle events", 0, 0, 0);
    bus("R4 cnt zero", 0, 4'h2, 1, 0, 0, 16'h0000);
    evts("R4 idle events2", 0, 0, 0);
    // R2 R3 R5 counting
    bus("R6 disable", 1, 4'h1, 0, 16'h0000, 0, 16'h0000);
    bus("R3 cmpA=4", 1, 4'h4, 1, 16'h0004, 0, 16'h0000);
    bus("R5 cmpB=2", 1, 4'h6, 1, 16'h0002, 0, 16'h0000);
    bus("R2 enable", 1, 4'h1, 0, 16'h0080, 0, 16'h0000);
    bus("R2 cnt0", 0, 4'h2, 1, 0, 0, 16'h0000);
    bus("R2 cnt1", 0, 4'h2, 1, 0, 0, 16'h0001);
    bus("R2 cnt2", 0, 4'h2, 1, 0, 0, 16'h0002);
    evts("R3 cnt3", 0, 0, 0);
    waitn(1);
    evts("R3 match A", 0, 1, 0);
    waitn(1);
    evts("R3 period", 1, 0, 0);
    waitn(2);
    evts("R5 match B", 0, 0, 1);
    // R6 stop and restart
    bus("R6 stop", 1, 4'h1, 0, 16'h0000, 0, 16'h0000);
    evts("R6 stopped events", 0, 0, 0);
    bus("R6 cnt zero", 0, 4'h2, 1, 0, 0, 16'h0000);
    waitn(3);
    evts("R6 still stopped", 0, 0, 0);
    bus("R6 reenable", 1, 4'h1, 0, 16'h0080, 0, 16'h0000);
    bus("R6 cnt0", 0, 4'h2, 1, 0, 0, 16'h0000);
    bus("R6 cnt1", 0, 4'h2, 1, 0, 0, 16'h0001);
    bus("R6 rewrite en", 1, 4'h1, 0, 16'h0080, 0, 16'h0000);
    bus("R6 restart cnt0", 0, 4'h2, 1, 0, 0, 16'h0000);
    bus("R6 restart cnt1", 0, 4'h2, 0, 0, 0, 16'h0001);
    // R13 compare A lowered below count
    bus("R13 cmpA=200", 1, 4'h4, 1, 16'h00C8, 0, 16'h0000);
    waitn(17);
    bus("R13 cmpA=5", 1, 4'h4, 1, 16'h0005, 0, 16'h0000);
    evts("R13 above limit", 0, 0, 0);
    waitn(1);
    evts("R13 wrap period", 1, 0, 0);
    bus("R13 cnt after wrap", 0, 4'h2, 1, 0, 0, 16'h0000);
    // R4 compare A cleared while running
    bus("R4 cmpA cleared", 1, 4'h4, 1, 16'h0000, 0, 16'h0000);
    bus("R4 cnt idle", 0, 4'h2, 1, 0, 0, 16'h0000);
    waitn(2);
    evts("R4 idle after clear", 0, 0, 0);
    chk("R12 queue drained", {16'd0, (exp_q.size() != 0)}, 17'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule